// File: doc/BRIEF.md
# Host Port Memory Decoder for a Time Slot Switch

This block sits between an 8-bit asynchronous-style host bus and the internal memories of a time slot switch. It has a write-and-read control byte and three memories: a connection store for source selection, a connection store for per-channel flags, and a data store that the host may only read. The host bus has six address lines, an active-low select, an active-low strobe, a read/write level and an active-low acknowledge. Address line 5 chooses between the control byte and the memory window. In the memory window, lines 4..0 give one of 32 channels, and the stream page held in the control byte supplies the upper bits of the memory address.

The switching datapath owns the memories and lets the host in only at spare slots. A memory access is therefore presented as a request with a target, address and write data, and it completes when the datapath returns a one-cycle grant. The acknowledge follows the grant, so its delay varies. A split mode sends host reads to the data store and host writes to the source connection store, so one address can be used to check the switch path.

Top module: `hostport_decoder`

## Requirements
- R1: After reset the control byte is 0, ack_n is high and mem_req is low.
- R2: An access with addr[5]=0 and addr[1:0]=0 reaches the control byte whatever addr[4:2] hold. A write stores all 8 bits, including the split flag (bit 7) and the processor-enable flag (bit 6), and a read returns the stored byte. The control byte is driven on ctrl.
- R3: An access with addr[5]=1 uses memory address {ctrl[2:0], addr[4:0]}, so the stream page is the high part and the channel is the low part.
- R4: Outside split mode, ctrl[4:3] selects the target. The value 01 is the source store (mem_tgt=1), 10 is the flag store (mem_tgt=2) and 11 is the data store (mem_tgt=3). mem_we equals 1 for a host write.
- R5: When ctrl[7]=1, a memory read targets the data store and a memory write targets the source store, whatever ctrl[4:3] hold.
- R6: A host write aimed at the data store raises no memory request, but the host still gets an acknowledge.
- R7: mem_req stays high until mem_gnt is sampled high. ack_n goes low only after the grant. On a read, the data presented on mem_rdata in the grant cycle becomes rdata.
- R8: ack_n stays low, and rdata stays unchanged, until cs_n or ds_n goes high. ack_n then returns high one clock later.
- R9: A memory-window access with ctrl[4:3]=00 outside split mode, or an access with addr[5]=0 and addr[1:0]≠0, changes no state and raises no request. It is acknowledged, and a read returns 0.
- R10: Each strobe causes at most one memory request, however long the host holds the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| ds_n | input | 1 | Host data strobe, active low |
| rnw | input | 1 | 1 = host read, 0 = host write |
| addr | input | 6 | Host address lines |
| wdata | input | DW | Host write data |
| rdata | output | DW | Host read data |
| ack_n | output | 1 | Data acknowledge, active low |
| ctrl | output | DW | Control byte, for use by the datapath |
| mem_req | output | 1 | Request for a memory slot |
| mem_gnt | input | 1 | One-cycle slot grant |
| mem_tgt | output | 2 | Target memory: 1 source, 2 flags, 3 data |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | SW+5 | Stream and channel address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with the grant |

## Verification
The bench uses the defaults DW=8 and SW=3. That gives eight stream pages of 32 channels, so every one of the 256 memory locations can be addressed. Pages 0, 2, 5 and 7 are used, so the first, middle and last locations are all reached. A bench model grants after a delay that changes from one access to the next, so the acknowledge latency is tested at several lengths. The acknowledge is held for several cycles, so a repeated request during the hold would appear as an extra transaction in the scoreboard.

// File: rtl/hostport_decoder.sv
module hostport_decoder #(
  parameter int DW = 8,
  parameter int SW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ds_n,
  input  logic             rnw,
  input  logic [5:0]       addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             ack_n,
  output logic [DW-1:0]    ctrl,
  output logic             mem_req,
  input  logic             mem_gnt,
  output logic [1:0]       mem_tgt,
  output logic             mem_we,
  output logic [SW+4:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int CW  = 5;
  localparam int MAW = SW + CW;
  localparam logic [1:0] T_NONE = 2'd0, T_CML = 2'd1, T_DM = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DONE} st_t;
  st_t st;

  logic [DW-1:0]  ctrl_q, rdata_q, wd_q;
  logic [1:0]     tgt_q;
  logic           we_q;
  logic [MAW-1:0] addr_q;
  logic [1:0]     dec_tgt;

  wire start   = (st == S_IDLE) && !cs_n && !ds_n;
  wire is_ctrl = !addr[5] && (addr[1:0] == 2'b00);

  always_comb begin
    if (!addr[5])       dec_tgt = T_NONE;
    else if (ctrl_q[7]) dec_tgt = rnw ? T_DM : T_CML;
    else                dec_tgt = ctrl_q[4:3];
  end

  wire go_mem = addr[5] && (dec_tgt != T_NONE) && !(dec_tgt == T_DM && !rnw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ctrl_q  <= '0;
      rdata_q <= '0;
      wd_q    <= '0;
      tgt_q   <= T_NONE;
      we_q    <= 1'b0;
      addr_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          tgt_q  <= dec_tgt;
          we_q   <= !rnw;
          addr_q <= {ctrl_q[SW-1:0], addr[CW-1:0]};
          wd_q   <= wdata;
          if (go_mem) st <= S_REQ;
          else begin
            st <= S_DONE;
            if (is_ctrl && !rnw) ctrl_q <= wdata;
            if (rnw) rdata_q <= is_ctrl ? ctrl_q : '0;
          end
        end
        S_REQ: if (mem_gnt) begin
          st <= S_DONE;
          if (!we_q) rdata_q <= mem_rdata;
        end
        default: if (cs_n || ds_n) st <= S_IDLE;
      endcase
    end
  end

  assign ack_n     = (st != S_DONE);
  assign mem_req   = (st == S_REQ);
  assign mem_tgt   = tgt_q;
  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = wd_q;
  assign rdata     = rdata_q;
  assign ctrl      = ctrl_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req);
  // R7
  no_ack_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ack_n);
  // R8
  rdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && !$past(ack_n) |-> $stable(rdata));
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n && (cs_n || ds_n) |=> ack_n);
  // R6
  dm_readonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !(mem_we && mem_tgt == T_DM));
  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |=> !mem_req);
endmodule

// File: tb/sim_hostport_decoder.sv
module sim_hostport_decoder;
  logic clk = 0, rst_n = 0;
  logic cs_n = 1, ds_n = 1, rnw = 1;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0, rdata, ctrl, mem_wdata, mem_rdata;
  logic ack_n, mem_req, mem_we, mem_gnt = 0;
  logic [1:0] mem_tgt;
  logic [7:0] mem_addr;

  hostport_decoder #(.DW(8), .SW(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ds_n(ds_n), .rnw(rnw), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ack_n(ack_n), .ctrl(ctrl),
    .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_tgt(mem_tgt), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata));

  always #2.5 clk = ~clk;

  int nvec = 0, nfail = 0;
  logic [7:0] cml [256];
  logic [7:0] cmh [256];
  logic [7:0] dm  [256];
  logic [18:0] exp_q [$];
  int dly = 1, cnt = 0;
  logic gnt_seen = 0;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always_comb begin
    case (mem_tgt)
      2'd1: mem_rdata = cml[mem_addr];
      2'd2: mem_rdata = cmh[mem_addr];
      2'd3: mem_rdata = dm[mem_addr];
      default: mem_rdata = 8'h00;
    endcase
  end

  always @(posedge clk) begin
    if (!mem_req) cnt <= 0;
    else cnt <= cnt + 1;
    mem_gnt <= mem_req && !mem_gnt && (cnt >= dly);
    if (mem_req && mem_gnt) begin
      gnt_seen = 1;
      if (mem_we) case (mem_tgt)
        2'd1: cml[mem_addr] <= mem_wdata;
        2'd2: cmh[mem_addr] <= mem_wdata;
        2'd3: dm[mem_addr]  <= mem_wdata;
        default: ;
      endcase
      if (exp_q.size() == 0)
        chk(0, "R10 unexpected memory request", {13'd0, mem_tgt, mem_we, mem_addr, mem_wdata}, 0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk(e == {mem_tgt, mem_we, mem_addr, mem_wdata}, "R3/R4/R5 memory transaction",
            {13'd0, mem_tgt, mem_we, mem_addr, mem_wdata}, {13'd0, e});
      end
    end
  end

  task automatic acc(input logic [5:0] a, input logic rd, input logic [7:0] wd,
                     input logic [1:0] etgt, input logic [7:0] emaddr,
                     input logic chk_rd, input logic [7:0] erd, input string tag);
    int w;
    logic [7:0] held;
    if (etgt != 0) exp_q.push_back({etgt, !rd, emaddr, rd ? 8'h00 : wd});
    gnt_seen = 0;
    dly = (nvec % 5) + 1;
    @(negedge clk);
    addr = a; rnw = rd; wdata = rd ? 8'h00 : wd; cs_n = 0; ds_n = 0;
    w = 0;
    do begin @(negedge clk); w++; end while (ack_n && w < 60);
    chk(!ack_n, {tag, " R7 ack arrives"}, ack_n, 0);
    if (etgt != 0) chk(gnt_seen, {tag, " R7 ack only after grant"}, gnt_seen, 1);
    else chk(w == 1, {tag, " R6/R9 ack without memory cycle"}, w, 1);
    if (chk_rd) chk(rdata == erd, {tag, " read data"}, rdata, erd);
    held = rdata;
    repeat (4) @(negedge clk);
    chk(!ack_n && rdata == held, {tag, " R8 ack and data held"}, {ack_n, rdata}, {1'b0, held});
    ds_n = 1;
    @(negedge clk);
    chk(ack_n, {tag, " R8 ack released"}, ack_n, 1);
    cs_n = 1;
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      cml[i] = 8'h00; cmh[i] = 8'h00; dm[i] = i[7:0] ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    chk(ctrl == 0 && ack_n && !mem_req, "R1 reset state", {ctrl, ack_n, mem_req}, 10'h2);
    rst_n = 1;
    @(negedge clk);
    // R2: control byte, A4..A2 don't care
    acc(6'b011100, 0, 8'h0D, 0, 0, 0, 0, "R2 ctrl write");
    chk(ctrl == 8'h0D, "R2 ctrl output", ctrl, 8'h0D);
    acc(6'b000000, 1, 0, 0, 0, 1, 8'h0D, "R2 ctrl read");
    // R3/R4: source store, page 5
    acc(6'h27, 0, 8'hA1, 2'd1, 8'd167, 0, 0, "R3 R4 source write");
    acc(6'h27, 1, 0, 2'd1, 8'd167, 1, 8'hA1, "R3 R4 source read");
    // flag store, page 7, channel 31
    acc(6'b000100, 0, 8'h17, 0, 0, 0, 0, "R2 ctrl write 17");
    acc(6'h3F, 0, 8'h3C, 2'd2, 8'd255, 0, 0, "R4 flag write top");
    acc(6'h3F, 1, 0, 2'd2, 8'd255, 1, 8'h3C, "R4 flag read top");
    // data store, page 0
    acc(6'b000000, 0, 8'h18, 0, 0, 0, 0, "R2 ctrl write 18");
    acc(6'h20, 1, 0, 2'd3, 8'd0, 1, 8'h5A, "R4 data read");
    acc(6'h20, 0, 8'hFF, 0, 0, 0, 0, "R6 data write dropped");
    acc(6'h20, 1, 0, 2'd3, 8'd0, 1, 8'h5A, "R6 data unchanged");
    // no target selected
    acc(6'b000000, 0, 8'h00, 0, 0, 0, 0, "R2 ctrl write 00");
    acc(6'h25, 0, 8'h77, 0, 0, 0, 0, "R9 no-target write");
    acc(6'h25, 1, 0, 0, 0, 1, 8'h00, "R9 no-target read");
    // split mode, msel=flags, page 2
    acc(6'b000000, 0, 8'h92, 0, 0, 0, 0, "R5 ctrl split");
    acc(6'h23, 0, 8'hC6, 2'd1, 8'd67, 0, 0, "R5 split write to source");
    acc(6'h23, 1, 0, 2'd3, 8'd67, 1, 8'd67 ^ 8'h5A, "R5 split read from data");
    acc(6'b000000, 0, 8'h0A, 0, 0, 0, 0, "R2 ctrl write 0A");
    acc(6'h23, 1, 0, 2'd1, 8'd67, 1, 8'hC6, "R5 source holds split write");
    // processor-enable flag and unmapped low addresses
    acc(6'b000000, 0, 8'h40, 0, 0, 0, 0, "R2 ctrl pe");
    acc(6'b000000, 1, 0, 0, 0, 1, 8'h40, "R2 ctrl pe read");
    acc(6'b000001, 0, 8'hEE, 0, 0, 0, 0, "R9 unmapped write");
    chk(ctrl == 8'h40, "R9 ctrl unchanged", ctrl, 8'h40);
    acc(6'b010110, 1, 0, 0, 0, 1, 8'h00, "R9 unmapped read");
    chk(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule